// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

This block holds two 16-bit down-counters behind a bank of byte-wide registers, together with an interrupt flag word and an interrupt enable word that combine into one interrupt request line. The first counter has a full 16-bit reload value. It reloads itself after passing through all-ones, so one period takes the reload value plus two ticks. The first counter has two modes, one-shot and continuous, which differ only in how often it raises its flag. The second counter is armed as a one-shot and then runs down and wraps freely.

Both counters advance only on cycles where the tick-enable input is high, so the count rate is set by whoever drives that strobe. Software selects a register through address bits [12:9], reads or writes one byte at a time, and services the interrupt by reading the counter low byte or by writing ones into the flag register. A strobe from a neighbouring shift engine can also raise a flag that reaches the interrupt line.

Top module: `duo_timer`

## Requirements
- R1: The register index is addr[12:9] and addr[8:0] are ignored. The map is: 0 T1 counter low, 1 T1 counter high, 2 T1 reload low, 3 T1 reload high, 4 T2 counter low, 5 T2 counter high, 6 mode, 7 flags, 8 enables, 9 T2 reload low. Other indices read 0x00 and ignore writes.
- R2: After reset both counters read 0xFFFF, the T1 reload is 0xFFFF, the T2 reload is 0x00, mode and flags read 0x00, enables read 0x80 and irq_o is low.
- R3: A write to index 0 or 2 sets the T1 reload low byte. A write to index 3 sets only the reload high byte. A write to index 1 sets the reload high byte and also loads the counter with {written byte, reload low byte}. Reload-only writes leave the counter unchanged.
- R4: On each tick T1 decrements. A tick taken at 0xFFFF loads the current reload value instead, so one period is reload + 2 ticks.
- R5: Flag bit 6 is set on the clock edge where a tick brings T1 to zero. When mode bits [7:6] are 01 (continuous) this happens every period. For any other mode value it happens only once after each write to index 1.
- R6: A write to index 4 stores the T2 reload low byte, which index 9 reads back. A write to index 5 loads T2 with {written byte, reload low byte}. T2 decrements on each tick and wraps from 0x0000 to 0xFFFF with no reload. Flag bit 5 is set once per load, when a tick brings T2 to zero.
- R7: A read of index 0 clears flag bit 6 and a read of index 4 clears flag bit 5. A flag set on the same cycle takes priority over the clear.
- R8: Index 7 reads {irq_o, flags[6:0]}. Writing it clears every flag bit whose written bit is 1.
- R9: A write to index 8 with bit 7 = 1 ORs bits [6:0] into the enables. With bit 7 = 0 it clears the enables where bits [6:0] are 1. A read returns {1, enables[6:0]}.
- R10: irq_o is high exactly when flags AND enables has bit 6 or bit 2 set. Flag bit 5 never drives irq_o.
- R11: A high shift_done_i sets flag bit 2.
- R12: A load write takes priority over a tick on the same cycle. With tick_i low the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable strobe for both counters |
| shift_done_i | input | 1 | Completion strobe from the shift engine, sets flag bit 2 |
| addr_i | input | 13 | Byte address, register index in bits [12:9] |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: 8-bit data, so the counters are 16 bits wide, and the register index starting at address bit 9. The bench limits the random high bytes it writes into the reload values to 0 or 1. This keeps periods short enough that thousands of random cycles pass through many zero crossings, T1 reloads from all-ones and T2 wraps. The random low address bits exercise the index decoding. Directed sequences cover the reload + 2 period, the one-shot versus continuous flag behaviour, a T2 flag that does not reach the interrupt line, and the enable set/clear encoding.

// File: rtl/duo_timer_pkg.sv
`timescale 1ns/1ps
package duo_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    // Flag and enable bit positions
    localparam int T1_BIT = 6;
    localparam int T2_BIT = 5;
    localparam int SR_BIT = 2;

    // Mode field value selecting continuous T1 flags
    localparam logic [1:0] MODE_CONT = 2'b01;

    typedef enum logic [SEL_W-1:0] {
        RS_T1_CNT_LO = 4'd0,
        RS_T1_CNT_HI = 4'd1,
        RS_T1_LAT_LO = 4'd2,
        RS_T1_LAT_HI = 4'd3,
        RS_T2_LO     = 4'd4,
        RS_T2_HI     = 4'd5,
        RS_MODE      = 4'd6,
        RS_FLAGS     = 4'd7,
        RS_ENABLES   = 4'd8,
        RS_T2_LAT    = 4'd9
    } reg_sel_e;

endpackage

// File: rtl/duo_timer_unit.sv
`timescale 1ns/1ps
module duo_timer_unit #(
    parameter int DATA_W = 8,
    parameter bit RELOAD = 1'b1,
    parameter logic [2*DATA_W-1:0] LATCH_RST = '1,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              set_lo_i,
    input  logic              set_hi_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wbyte_i,
    input  logic              repeat_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  latch_o,
    output logic              hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             armed;
    } unit_st_t;

    unit_st_t         st_d, st_q;
    logic [CNT_W-1:0] step_val;
    logic             hit;

    generate
        if (RELOAD) begin : g_reload
            assign step_val = (st_q.cnt == '1) ? st_q.latch : st_q.cnt - CNT_W'(1);
        end else begin : g_wrap
            assign step_val = st_q.cnt - CNT_W'(1);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (set_lo_i) st_d.latch[DATA_W-1:0]     = wbyte_i;
        if (set_hi_i) st_d.latch[CNT_W-1:DATA_W] = wbyte_i;
        if (load_i) begin
            st_d.cnt   = {wbyte_i, st_q.latch[DATA_W-1:0]};
            st_d.armed = 1'b1;
        end else if (tick_i) begin
            st_d.cnt = step_val;
            if (step_val == '0 && (repeat_i || st_q.armed)) begin
                hit = 1'b1;
                if (!repeat_i) st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '1;
            st_q.latch <= LATCH_RST;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign latch_o = st_q.latch;
    assign hit_o   = hit;

endmodule

// File: rtl/duo_timer_irq.sv
`timescale 1ns/1ps
module duo_timer_irq import duo_timer_pkg::*; #(
    parameter int DATA_W = BYTE_W,
    localparam int FLAG_W = DATA_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    input  logic              ier_wr_i,
    input  logic [DATA_W-1:0] wbyte_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] ier_o,
    output logic              irq_o
);

    localparam logic [FLAG_W-1:0] IRQ_MASK =
        (FLAG_W'(1) << T1_BIT) | (FLAG_W'(1) << SR_BIT);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] ier;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        if (ier_wr_i) begin
            if (wbyte_i[DATA_W-1]) st_d.ier = st_q.ier | wbyte_i[FLAG_W-1:0];
            else                   st_d.ier = st_q.ier & ~wbyte_i[FLAG_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign ier_o   = st_q.ier;
    assign irq_o   = |(st_q.flags & st_q.ier & IRQ_MASK);

endmodule

// File: rtl/duo_timer.sv
`timescale 1ns/1ps
module duo_timer import duo_timer_pkg::*; #(
    parameter int DATA_W  = BYTE_W,
    parameter int SEL_LSB = 9,
    localparam int ADDR_W = SEL_LSB + SEL_W,
    localparam int CNT_W  = 2 * DATA_W,
    localparam int FLAG_W = DATA_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              shift_done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mode;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [SEL_W-1:0]  sel;
    logic              t1_set_lo, t1_set_hi, t1_load, t2_set_lo, t2_load;
    logic              mode_wr, flag_wr, ier_wr, t1_cont;
    logic              t1_hit, t2_hit;
    logic [CNT_W-1:0]  t1_cnt, t1_latch, t2_cnt, t2_latch;
    logic [FLAG_W-1:0] set_vec, clr_vec, flags, ier;
    logic              unused_bits;

    assign sel = addr_i[ADDR_W-1:SEL_LSB];
    assign unused_bits = ^{addr_i[SEL_LSB-1:0], t2_latch[CNT_W-1:DATA_W]};

    // Write decode
    assign t1_set_lo = wr_i && (sel == RS_T1_CNT_LO || sel == RS_T1_LAT_LO);
    assign t1_set_hi = wr_i && (sel == RS_T1_CNT_HI || sel == RS_T1_LAT_HI);
    assign t1_load   = wr_i && (sel == RS_T1_CNT_HI);
    assign t2_set_lo = wr_i && (sel == RS_T2_LO);
    assign t2_load   = wr_i && (sel == RS_T2_HI);
    assign mode_wr   = wr_i && (sel == RS_MODE);
    assign flag_wr   = wr_i && (sel == RS_FLAGS);
    assign ier_wr    = wr_i && (sel == RS_ENABLES);

    always_comb begin
        st_d = st_q;
        if (mode_wr) st_d.mode = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign t1_cont = (st_q.mode[DATA_W-1 -: 2] == MODE_CONT);

    duo_timer_unit #(
        .DATA_W   (DATA_W),
        .RELOAD   (1'b1),
        .LATCH_RST({CNT_W{1'b1}})
    ) u_t1 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .set_lo_i(t1_set_lo),
        .set_hi_i(t1_set_hi),
        .load_i  (t1_load),
        .wbyte_i (wdata_i),
        .repeat_i(t1_cont),
        .cnt_o   (t1_cnt),
        .latch_o (t1_latch),
        .hit_o   (t1_hit)
    );

    duo_timer_unit #(
        .DATA_W   (DATA_W),
        .RELOAD   (1'b0),
        .LATCH_RST({CNT_W{1'b0}})
    ) u_t2 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .set_lo_i(t2_set_lo),
        .set_hi_i(1'b0),
        .load_i  (t2_load),
        .wbyte_i (wdata_i),
        .repeat_i(1'b0),
        .cnt_o   (t2_cnt),
        .latch_o (t2_latch),
        .hit_o   (t2_hit)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[T1_BIT] = t1_hit;
        set_vec[T2_BIT] = t2_hit;
        set_vec[SR_BIT] = shift_done_i;
        clr_vec         = '0;
        if (rd_i && sel == RS_T1_CNT_LO) clr_vec[T1_BIT] = 1'b1;
        if (rd_i && sel == RS_T2_LO)     clr_vec[T2_BIT] = 1'b1;
        if (flag_wr) clr_vec = clr_vec | wdata_i[FLAG_W-1:0];
    end

    duo_timer_irq #(.DATA_W(DATA_W)) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .ier_wr_i(ier_wr),
        .wbyte_i (wdata_i),
        .flags_o (flags),
        .ier_o   (ier),
        .irq_o   (irq_o)
    );

    always_comb begin
        unique case (sel)
            RS_T1_CNT_LO: rdata_o = t1_cnt[DATA_W-1:0];
            RS_T1_CNT_HI: rdata_o = t1_cnt[CNT_W-1:DATA_W];
            RS_T1_LAT_LO: rdata_o = t1_latch[DATA_W-1:0];
            RS_T1_LAT_HI: rdata_o = t1_latch[CNT_W-1:DATA_W];
            RS_T2_LO:     rdata_o = t2_cnt[DATA_W-1:0];
            RS_T2_HI:     rdata_o = t2_cnt[CNT_W-1:DATA_W];
            RS_MODE:      rdata_o = st_q.mode;
            RS_FLAGS:     rdata_o = {irq_o, flags};
            RS_ENABLES:   rdata_o = {1'b1, ier};
            RS_T2_LAT:    rdata_o = t2_latch[DATA_W-1:0];
            default:      rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/duo_timer_chk.sv
`timescale 1ns/1ps
module duo_timer_chk #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W,
    localparam int FLAG_W = DATA_W - 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              t1_load,
    input logic              t2_load,
    input logic              ier_wr,
    input logic [DATA_W-1:0] wdata_i,
    input logic [CNT_W-1:0]  t1_cnt,
    input logic [CNT_W-1:0]  t1_latch,
    input logic [CNT_W-1:0]  t2_cnt,
    input logic [CNT_W-1:0]  t2_latch,
    input logic [FLAG_W-1:0] ier,
    input logic              irq_o
);

    localparam logic [FLAG_W-1:0] LINE_MASK = FLAG_W'(7'h44);

    // R4
    t1_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !t1_load && t1_cnt != '1) |=> (t1_cnt == $past(t1_cnt) - CNT_W'(1)));

    // R4
    t1_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !t1_load && t1_cnt == '1) |=> (t1_cnt == $past(t1_latch)));

    // R12
    t2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !t2_load) |=> $stable(t2_cnt));

    // R6
    t2_latch_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t2_load |=> (t2_latch[CNT_W-1:DATA_W] == '0));

    // R9
    ier_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ier_wr && wdata_i[DATA_W-1])
        |=> ((ier & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0])));

    // R10
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((ier & LINE_MASK) != '0));

endmodule

bind duo_timer duo_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .t1_load (t1_load),
    .t2_load (t2_load),
    .ier_wr  (ier_wr),
    .wdata_i (wdata_i),
    .t1_cnt  (t1_cnt),
    .t1_latch(t1_latch),
    .t2_cnt  (t2_cnt),
    .t2_latch(t2_latch),
    .ier     (ier),
    .irq_o   (irq_o)
);

// File: tb/duo_timer_bench.sv
`timescale 1ns/1ps
module duo_timer_bench;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0, sd = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    always #10 clk = ~clk;

    duo_timer u_duo_timer (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .shift_done_i(sd),
        .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;

    // Reference state built from the requirements
    logic [15:0] m_t1c, m_t1l, m_t2c;
    logic [7:0]  m_t2l, m_mode;
    logic [6:0]  m_flag, m_ier;
    bit          m_arm1, m_arm2;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return |(m_flag & m_ier & 7'h44);
    endfunction

    function automatic logic [7:0] m_read(logic [3:0] s);
        case (s)
            4'd0: return m_t1c[7:0];
            4'd1: return m_t1c[15:8];
            4'd2: return m_t1l[7:0];
            4'd3: return m_t1l[15:8];
            4'd4: return m_t2c[7:0];
            4'd5: return m_t2c[15:8];
            4'd6: return m_mode;
            4'd7: return {m_irq(), m_flag};
            4'd8: return {1'b1, m_ier};
            4'd9: return m_t2l;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] s);
        case (s)
            4'd0, 4'd1: return "R4";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd9: return "R6";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic model_reset();
        m_t1c = 16'hFFFF; m_t1l = 16'hFFFF; m_t2c = 16'hFFFF; m_t2l = 8'h00;
        m_mode = 8'h00; m_flag = '0; m_ier = '0; m_arm1 = 0; m_arm2 = 0;
    endtask

    task automatic model_advance(bit w, bit r, logic [3:0] s, logic [7:0] d, bit t, bit shd);
        logic [15:0] n1, n2;
        logic [6:0]  setv, clrv;
        bit          h1 = 0, h2 = 0;
        bit          cont = (m_mode[7:6] == 2'b01);
        n1 = m_t1c; n2 = m_t2c;
        if (w && s == 4'd1) begin
            n1 = {d, m_t1l[7:0]}; m_arm1 = 1;
        end else if (t) begin
            n1 = (m_t1c == 16'hFFFF) ? m_t1l : m_t1c - 16'd1;
            if (n1 == 0 && (cont || m_arm1)) begin h1 = 1; if (!cont) m_arm1 = 0; end
        end
        if (w && s == 4'd5) begin
            n2 = {d, m_t2l}; m_arm2 = 1;
        end else if (t) begin
            n2 = m_t2c - 16'd1;
            if (n2 == 0 && m_arm2) begin h2 = 1; m_arm2 = 0; end
        end
        if (w && (s == 4'd0 || s == 4'd2)) m_t1l[7:0]  = d;
        if (w && (s == 4'd1 || s == 4'd3)) m_t1l[15:8] = d;
        if (w && s == 4'd4) m_t2l = d;
        if (w && s == 4'd6) m_mode = d;
        if (w && s == 4'd8) m_ier = d[7] ? (m_ier | d[6:0]) : (m_ier & ~d[6:0]);
        clrv = '0;
        if (r && s == 4'd0) clrv[6] = 1;
        if (r && s == 4'd4) clrv[5] = 1;
        if (w && s == 4'd7) clrv = clrv | d[6:0];
        setv = {h1, h2, 2'b00, shd, 2'b00};
        m_flag = (m_flag & ~clrv) | setv;
        m_t1c = n1; m_t2c = n2;
    endtask

    // One bus cycle: drive, compare read data and irq, advance the reference
    task automatic step(bit w, bit r, logic [3:0] s, logic [7:0] d, bit t, bit shd,
                        output logic [7:0] seen, output logic seen_irq);
        @(negedge clk);
        wr = w; rd = r; addr = {s, 9'($urandom)}; wdata = d; tick = t; sd = shd;
        #1;
        seen = rdata; seen_irq = irq;
        check(tag_of(s), {8'h00, rdata}, {8'h00, m_read(s)});
        check("R10", {15'h0, irq}, {15'h0, m_irq()});
        model_advance(w, r, s, d, t, shd);
        @(posedge clk);
    endtask

    task automatic wreg(logic [3:0] s, logic [7:0] d);
        logic [7:0] v; logic q;
        step(1, 0, s, d, 0, 0, v, q);
    endtask

    task automatic ticks(int n);
        logic [7:0] v; logic q;
        for (int i = 0; i < n; i++) step(0, 0, 4'd15, 8'h00, 1, 0, v, q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        logic       q;
        logic [7:0] rst_exp [10];
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        rst_exp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h00};
        for (int s = 0; s < 10; s++) begin
            step(0, 0, 4'(s), 8'h00, 0, 0, v, q);
            check("R2", {8'h00, v}, {8'h00, rst_exp[s]});
            check("R2", {15'h0, q}, 16'h0000);
        end

        // R3 reload-only writes keep the counter, index 1 loads it
        wreg(4'd2, 8'h03); wreg(4'd3, 8'h00);
        step(0, 0, 4'd0, 8'h00, 0, 0, v, q); check("R3", {8'h00, v}, 16'h00FF);
        wreg(4'd1, 8'h00);
        step(0, 0, 4'd0, 8'h00, 0, 0, v, q); check("R3", {8'h00, v}, 16'h0003);

        // R4 / R5 continuous: reload 3 gives a 5-tick period
        wreg(4'd6, 8'h40); wreg(4'd8, 8'hC0);
        ticks(3);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R5", {8'h00, v & 8'hC0}, 16'h00C0);
        ticks(1);
        step(0, 0, 4'd1, 8'h00, 0, 0, v, q); check("R4", {8'h00, v}, 16'h00FF);
        ticks(1);
        step(0, 0, 4'd0, 8'h00, 0, 0, v, q); check("R4", {8'h00, v}, 16'h0003);
        // R7 read of index 0 clears the T1 flag
        step(0, 1, 4'd0, 8'h00, 0, 0, v, q);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R7", {15'h0, q}, 16'h0000);
        ticks(5);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R5", {15'h0, q}, 16'h0001);

        // R5 one-shot: a single flag per load
        wreg(4'd6, 8'h00); wreg(4'd1, 8'h00);
        step(0, 1, 4'd0, 8'h00, 0, 0, v, q);
        ticks(5);
        step(0, 1, 4'd0, 8'h00, 0, 0, v, q); check("R5", {15'h0, q}, 16'h0001);
        ticks(10);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R5", {15'h0, q}, 16'h0000);

        // R6 / R10 T2 flag never reaches the line
        wreg(4'd8, 8'h40); wreg(4'd8, 8'hA0);
        wreg(4'd4, 8'h02); wreg(4'd5, 8'h00);
        step(0, 0, 4'd9, 8'h00, 0, 0, v, q); check("R6", {8'h00, v}, 16'h0002);
        ticks(2);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q);
        check("R6", {8'h00, v & 8'h20}, 16'h0020); check("R10", {15'h0, q}, 16'h0000);
        ticks(2);
        step(0, 0, 4'd4, 8'h00, 0, 0, v, q); check("R6", {8'h00, v}, 16'h00FE);
        // R12 counters hold without tick
        step(0, 0, 4'd4, 8'h00, 0, 0, v2, q); check("R12", {8'h00, v2}, {8'h00, v});

        // R11 / R8 shift strobe raises bit 2; writing ones clears it
        wreg(4'd8, 8'h84);
        step(0, 0, 4'd15, 8'h00, 0, 1, v, q);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R11", {15'h0, q}, 16'h0001);
        wreg(4'd7, 8'h04);
        step(0, 0, 4'd7, 8'h00, 0, 0, v, q); check("R8", {8'h00, v & 8'h84}, 16'h0000);

        // R9 clearing every enable
        wreg(4'd8, 8'h7F);
        step(0, 0, 4'd8, 8'h00, 0, 0, v, q); check("R9", {8'h00, v}, 16'h0080);
        // R1 unused index ignores writes
        wreg(4'd12, 8'h5A);
        step(0, 0, 4'd12, 8'h00, 0, 0, v, q); check("R1", {8'h00, v}, 16'h0000);

        // Constrained random traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] s = 4'($urandom % 11);
            logic [7:0] d = 8'($urandom);
            bit w = ($urandom % 4) == 0;
            bit r = ($urandom % 3) == 0;
            if (s == 4'd10) s = 4'($urandom % 6 + 10);
            if (s == 4'd1 || s == 4'd3 || s == 4'd5) d = 8'($urandom % 2);
            else if (s <= 4'd4) d = 8'($urandom % 8);
            step(w, r, s, d, ($urandom % 5) != 0, ($urandom % 20) == 0, v, q);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule